// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an I2C bus master read and write a bank of eleven byte-wide registers that sit outside it. It watches already synchronised SCL and SDA samples, recognises START, repeated START and STOP, matches the control byte against a fixed device identity plus three strap pins, and then walks an internal address pointer through the bank. It does not own the register contents: it presents an address, a write byte with a one-cycle write strobe, and a one-cycle read strobe, and it takes the read byte back from the bank in the same cycle.

A write transaction is control byte, pointer byte, then any number of data bytes. A read first sets the pointer with a write-type control byte and a pointer byte, then a repeated START and a control byte with the direction bit set. The slave returns bytes until the master answers one with NACK. A hold input freezes the pointer so that a single register can be polled or rewritten again and again; otherwise the pointer steps after each data byte and wraps back to zero after the last register. The only output on the bus side is an enable that pulls SDA low; the pad and its open-drain driver sit outside.

Top module: `i2cx_regslave`

## Requirements
- R1: A control byte is accepted when its upper seven bits equal 0100 followed by strap_i[2:0] (bit 0 of the byte is the direction, 0 write, 1 read); the slave then pulls SDA low for the ninth clock of that byte.
- R2: A control byte whose identity differs is not acknowledged, and the slave neither pulls SDA nor strobes the bank for any later clocks until the next START.
- R3: In a write, the byte after the control byte loads the pointer, and each complete data byte after it gives exactly one rb_wr_o pulse with rb_addr_o equal to the pointer and rb_wdata_o equal to the byte; every byte is acknowledged.
- R4: After a repeated START with a read control byte, the slave sends the register at the pointer, most significant bit first, with one rb_rd_o pulse per byte sent.
- R5: With seq_hold_i low the pointer advances by one after every data byte written or read, and from 0x0A (or any higher value) it goes to 0x00.
- R6: With seq_hold_i high the pointer does not move, so further data bytes rewrite or re-read the same register.
- R7: A data byte interrupted by STOP or repeated START before its eighth bit is never written and does not move the pointer.
- R8: Data bytes aimed at 0x08 or at any address above 0x0A are acknowledged but give no rb_wr_o pulse.
- R9: Reading an address above 0x0A returns 0x00 on the bus and gives no rb_rd_o pulse.
- R10: When the master answers a read byte with NACK, the slave releases SDA and ignores further clocks until START or STOP.
- R11: During and right after reset, sda_pull_o, rb_wr_o and rb_rd_o are low and the pointer is 0x00.
- R12: After a STOP the slave does not pull SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (bus line, including own pull) |
| strap_i | input | 3 | Hardware identity strap, low three bits of the device identity |
| seq_hold_i | input | 1 | 1 freezes the address pointer, 0 lets it advance |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| rb_addr_o | output | 8 | Register bank address (current pointer) |
| rb_wdata_o | output | 8 | Register bank write byte |
| rb_wr_o | output | 1 | One-cycle write strobe |
| rb_rdata_i | input | 8 | Register bank read byte for rb_addr_o, combinational |
| rb_rd_o | output | 1 | One-cycle read strobe, same cycle the byte is taken |

## Verification
The hardest state to reach from the pins is a data byte cut short in the middle: the slave has shifted in some bits of a byte that must never reach the bank, and the pointer must stay where it was so that the next read lands on the right register. The bench master is built from single-bit tasks, so it can emit three or four data bits and then a STOP or repeated START, then read back through the pointer to prove both the missing write and the unmoved pointer. Pointer wrap is reached by a sequential write and read that start at 0x09 and run three bytes.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } fsm_t;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDR,
    K_DATA
  } kind_t;
endpackage

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  // SDA edges while SCL stays high mark bus conditions
  always_comb begin
    scl_rise  = scl & ~scl_q;
    scl_fall  = ~scl & scl_q;
    bus_start = scl & scl_q & sda_q & ~sda;
    bus_stop  = scl & scl_q & ~sda_q & sda;
  end
endmodule

// File: rtl/i2cx_addr_ptr.sv
module i2cx_addr_ptr #(
  parameter int AW      = 8,
  parameter int NREGS   = 11,
  parameter int RO_ADDR = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          hold,
  output logic [AW-1:0] ptr,
  output logic          wr_ok,
  output logic          rd_ok
);
  localparam logic [AW-1:0] LAST_A = AW'(NREGS - 1);
  localparam logic [AW-1:0] RO_A   = AW'(RO_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (adv && !hold) begin
      ptr <= (ptr >= LAST_A) ? '0 : ptr + AW'(1);
    end
  end

  always_comb begin
    rd_ok = (ptr <= LAST_A);
    wr_ok = rd_ok && (ptr != RO_A);
  end

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold && !load && ptr >= LAST_A) |=> (ptr == '0));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold && !load && ptr < LAST_A) |=> (ptr == $past(ptr) + AW'(1)));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(ptr));
endmodule

// File: rtl/i2cx_regslave.sv
module i2cx_regslave #(
  parameter int         NREGS       = 11,
  parameter int         RO_ADDR     = 8,
  parameter int         STRAP_W     = 3,
  parameter logic [6:0] DEV_ID_BASE = 7'b0100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               seq_hold_i,
  output logic               sda_pull_o,
  output logic [7:0]         rb_addr_o,
  output logic [7:0]         rb_wdata_o,
  output logic               rb_wr_o,
  input  logic [7:0]         rb_rdata_i,
  output logic               rb_rd_o
);
  import i2cx_pkg::*;

  localparam int            CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LASTB = CNT_W'(BYTE_W - 1);
  localparam logic [7:0]    LAST_A = 8'(NREGS - 1);
  localparam logic [7:0]    RO_A   = 8'(RO_ADDR);

  logic scl_rise, scl_fall, ev_start, ev_stop;

  fsm_t             state;
  kind_t            kind;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       rx_sr, tx_sr;
  logic             rd_mode, mst_ack;

  logic [6:0] dev_id;
  logic       id_hit, byte_in_done, wr_fire, ptr_load, tx_done, ptr_adv, rd_fire;
  logic       wr_ok, rd_ok;
  logic [7:0] ptr, rd_byte;

  i2cx_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_i),
    .sda      (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(ev_start),
    .bus_stop (ev_stop)
  );

  always_comb begin
    dev_id                = DEV_ID_BASE;
    dev_id[STRAP_W-1:0]   = strap_i;
    id_hit                = (rx_sr[7:1] == dev_id);
    byte_in_done          = (state == ST_RX) && scl_fall && (bitcnt == FULL);
    wr_fire               = byte_in_done && (kind == K_DATA);
    ptr_load              = byte_in_done && (kind == K_ADDR);
    tx_done               = (state == ST_TX) && scl_fall && (bitcnt == LASTB);
    ptr_adv               = wr_fire || tx_done;
    rd_fire               = scl_fall &&
                            (((state == ST_ACK) && (kind == K_CTRL) && rd_mode) ||
                             ((state == ST_RACK) && mst_ack));
    rd_byte               = rd_ok ? rb_rdata_i : 8'h00;
  end

  i2cx_addr_ptr #(
    .AW     (8),
    .NREGS  (NREGS),
    .RO_ADDR(RO_ADDR)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .load_val(rx_sr),
    .adv     (ptr_adv),
    .hold    (seq_hold_i),
    .ptr     (ptr),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= K_CTRL;
      bitcnt  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rd_mode <= 1'b0;
      mst_ack <= 1'b0;
    end else if (ev_start) begin
      state  <= ST_RX;
      kind   <= K_CTRL;
      bitcnt <= '0;
    end else if (ev_stop) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && bitcnt != FULL) begin
            rx_sr  <= {rx_sr[6:0], sda_i};
            bitcnt <= bitcnt + CNT_W'(1);
          end
          if (byte_in_done) begin
            bitcnt <= '0;
            if (kind == K_CTRL) begin
              rd_mode <= rx_sr[0];
              state   <= id_hit ? ST_ACK : ST_IGNORE;
            end else begin
              state <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (kind == K_CTRL && rd_mode) begin
              state <= ST_TX;
              tx_sr <= rd_byte;
            end else begin
              state <= ST_RX;
              kind  <= (kind == K_CTRL) ? K_ADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LASTB) begin
              state  <= ST_RACK;
              bitcnt <= '0;
            end else begin
              tx_sr  <= {tx_sr[6:0], 1'b0};
              bitcnt <= bitcnt + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mst_ack <= ~sda_i;
          if (scl_fall) begin
            if (mst_ack) begin
              state  <= ST_TX;
              tx_sr  <= rd_byte;
              bitcnt <= '0;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sda_pull_o = (state == ST_ACK) || ((state == ST_TX) && !tx_sr[7]);
    rb_addr_o  = ptr;
    rb_wdata_o = rx_sr;
    rb_wr_o    = wr_fire && wr_ok;
    rb_rd_o    = rd_fire && rd_ok;
  end

  assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_pull_o);

  assert_start_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !rb_wr_o);

  assert_wr_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_wr_o |-> (rb_addr_o != RO_A) && (rb_addr_o <= LAST_A));

  assert_rd_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rd_o |-> (rb_addr_o <= LAST_A));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rb_wr_o && rb_rd_o));

  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE && !ev_start) |=> !sda_pull_o && !rb_wr_o);
endmodule

// File: tb/i2cx_regslave_bench.sv
module i2cx_regslave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       hold = 1'b0;
  logic       sda_line;
  logic       sda_pull_o, rb_wr_o, rb_rd_o;
  logic [7:0] rb_addr_o, rb_wdata_o, rb_rdata_i;

  logic [7:0] bank [0:10];
  int         wr_cnt = 0;
  int         rd_cnt = 0;
  int         coll   = 0;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  localparam logic [7:0] CW = 8'h4A;
  localparam logic [7:0] CR = 8'h4B;
  localparam logic [7:0] CBAD = 8'h48;

  // {address, write byte, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'h3C, 8'h3C},
    {8'h01, 8'hA5, 8'hA5},
    {8'h07, 8'h0F, 8'h0F},
    {8'h08, 8'h77, 8'h18},
    {8'h0A, 8'hC3, 8'hC3},
    {8'h0B, 8'h99, 8'h00},
    {8'h0C, 8'h44, 8'h00},
    {8'hFF, 8'h12, 8'h00}
  };

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_o;
  assign rb_rdata_i = (rb_addr_o < 8'd11) ? bank[rb_addr_o[3:0]] : 8'hEE;

  i2cx_regslave u_i2cx_regslave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .seq_hold_i(hold),
    .sda_pull_o(sda_pull_o),
    .rb_addr_o (rb_addr_o),
    .rb_wdata_o(rb_wdata_o),
    .rb_wr_o   (rb_wr_o),
    .rb_rdata_i(rb_rdata_i),
    .rb_rd_o   (rb_rd_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 11; i++) bank[i] <= 8'(8'h10 + i);
    end else begin
      if (rb_wr_o) begin
        if (rb_addr_o < 8'd11) bank[rb_addr_o[3:0]] <= rb_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end
      if (rb_rd_o) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; half();
    scl = 1'b1; half();
    if (b && !sda_line) coll++;
    scl = 1'b0; half();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; half();
    scl = 1'b1; half();
    b = sda_line;
    scl = 1'b0; half();
  endtask

  task automatic bstart();
    sda_m = 1'b1; half();
    scl = 1'b1; half();
    sda_m = 1'b0; half();
    scl = 1'b0; half();
  endtask

  task automatic bstop();
    sda_m = 1'b0; half();
    scl = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack_n);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
  endtask

  task automatic open_write(input logic [7:0] addr, output bit ok);
    logic a0, a1;
    bstart();
    send_byte(CW, a0);
    send_byte(addr, a1);
    ok = !a0 && !a1;
  endtask

  task automatic open_read(output bit ok);
    logic a;
    bstart();
    send_byte(CR, a);
    ok = !a;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit ok, ok2;
    logic a;
    logic [7:0] d, d1, d2;
    int w0, r0;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk(sda_pull_o == 1'b0, "R11 pull in reset", sda_pull_o, 0);
    chk(rb_wr_o == 1'b0 && rb_rd_o == 1'b0, "R11 strobes in reset", {rb_wr_o, rb_rd_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rb_addr_o == 8'h00, "R11 pointer after reset", rb_addr_o, 0);
    open_read(ok);
    recv_byte(1'b1, d);
    bstop();
    chk(ok, "R1 read control ack", ok, 1);
    chk(d == 8'h10, "R11 read at reset pointer", d, 8'h10);

    // table walk: single write, then read-back through the pointer
    for (int v = 0; v < 8; v++) begin
      logic [7:0] va, vw, ve;
      bit legal_w, legal_r;
      {va, vw, ve} = VEC[v];
      legal_w = (va <= 8'h0A) && (va != 8'h08);
      legal_r = (va <= 8'h0A);
      w0 = wr_cnt;
      open_write(va, ok);
      send_byte(vw, a);
      bstop();
      chk(ok && !a, "R1/R8 all bytes acked", {ok, a}, 2'b10);
      chk((wr_cnt - w0) == (legal_w ? 1 : 0), "R3/R8 write strobe count", wr_cnt - w0, legal_w ? 1 : 0);
      r0 = rd_cnt;
      open_write(va, ok);
      open_read(ok2);
      recv_byte(1'b1, d);
      bstop();
      chk(d == ve, "R4/R9 read-back byte", d, ve);
      chk((rd_cnt - r0) == (legal_r ? 1 : 0), "R9 read strobe count", rd_cnt - r0, legal_r ? 1 : 0);
    end

    // R5: sequential write and read across the wrap point
    open_write(8'h09, ok);
    send_byte(8'hA1, a); send_byte(8'hA2, a); send_byte(8'hA3, a);
    bstop();
    chk(bank[9] == 8'hA1 && bank[10] == 8'hA2, "R5 sequential write", {bank[9], bank[10]}, 16'hA1A2);
    chk(bank[0] == 8'hA3, "R5 write wraps to 0x00", bank[0], 8'hA3);
    open_write(8'h09, ok);
    open_read(ok);
    recv_byte(1'b0, d); recv_byte(1'b0, d1); recv_byte(1'b1, d2);
    bstop();
    chk({d, d1, d2} == 24'hA1A2A3, "R5 sequential read wraps", {d, d1, d2}, 24'hA1A2A3);

    // R6: pointer frozen
    hold = 1'b1;
    open_write(8'h03, ok);
    send_byte(8'h31, a); send_byte(8'h32, a);
    bstop();
    chk(bank[3] == 8'h32, "R6 rewrite same register", bank[3], 8'h32);
    chk(bank[4] == 8'h14, "R6 next register untouched", bank[4], 8'h14);
    open_write(8'h03, ok);
    open_read(ok);
    recv_byte(1'b0, d); recv_byte(1'b0, d1); recv_byte(1'b1, d2);
    bstop();
    chk({d, d1, d2} == 24'h323232, "R6 repeated polling read", {d, d1, d2}, 24'h323232);
    hold = 1'b0;

    // R7: byte cut by STOP
    w0 = wr_cnt;
    open_write(8'h05, ok);
    send_byte(8'h55, a);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bstop();
    chk((wr_cnt - w0) == 1, "R7 partial byte before STOP dropped", wr_cnt - w0, 1);
    chk(bank[5] == 8'h55 && bank[6] == 8'h16, "R7 bank after STOP cut", {bank[5], bank[6]}, 16'h5516);

    // R7: byte cut by repeated START, pointer must not move
    open_write(8'h06, ok);
    send_byte(8'h66, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    open_read(ok);
    recv_byte(1'b1, d);
    bstop();
    chk(d == 8'h0F, "R7 read after repeated START cut", d, 8'h0F);
    chk(bank[6] == 8'h66 && bank[7] == 8'h0F, "R7 no write of cut byte", {bank[6], bank[7]}, 16'h660F);

    // R10: master NACK ends the read
    open_write(8'h01, ok);
    open_read(ok);
    recv_byte(1'b1, d);
    chk(d == 8'hA5, "R4 single read", d, 8'hA5);
    w0 = coll;
    send_byte(8'hFF, a);
    chk(a == 1'b1 && coll == w0, "R10 bus released after NACK", {a, 8'(coll - w0)}, 9'h100);
    bstop();

    // R2: identity mismatch
    w0 = wr_cnt;
    bstart();
    send_byte(CBAD, a);
    chk(a == 1'b1, "R2 mismatched control not acked", a, 1);
    send_byte(8'h02, a);
    send_byte(8'h99, d[0]);
    chk(a == 1'b1 && d[0] == 1'b1, "R2 later bytes not acked", {a, d[0]}, 2'b11);
    bstop();
    chk(wr_cnt == w0, "R2 no write after mismatch", wr_cnt - w0, 0);
    open_write(8'h02, ok);
    open_read(ok);
    recv_byte(1'b1, d);
    bstop();
    chk(d == 8'h12, "R2 register intact", d, 8'h12);

    // R12: STOP right after an acknowledged write
    open_write(8'h04, ok);
    send_byte(8'h44, a);
    bstop();
    repeat (2) @(negedge clk);
    chk(sda_pull_o == 1'b0 && sda_line == 1'b1, "R12 released after STOP", sda_pull_o, 0);
    chk(bank[4] == 8'h44, "R3 plain write", bank[4], 8'h44);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule